// File: doc/BRIEF.md
# Reset Sequencer with Wake Delay

This block generates the internal reset of a small microcontroller. A single one-shot delay counter, clocked by a slow timebase strobe, is shared by three reset sources: loss of supply (power-good low, including a low-voltage dip), a watchdog that was not refreshed in time, and a wake from stop mode. Internal reset is held from the last trigger until the delay has counted out. This gives the main oscillator time to settle before the CPU runs.

A recovery control register lets firmware skip the delay for stop-mode wake only. In that case the wake input must stay active for a fixed number of clock edges before a one-cycle reset pulse is passed on, and shorter glitches have no effect. The same register holds a warm-start flag that only a power-on reset clears, the delay-enable bit and the watchdog enable. Two wake-source select registers sit beside it and keep their contents through every reset except power-on. A 2-bit cause code reports which source produced the most recent reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1, `rst_cause` is 2'b01 (power), the control register (address 0) reads 8'h20 and both select registers (addresses 1 and 2) read 8'h00. After `por_n` rises, `rst_out` stays 1 until the delay has counted out.
- R2: After the last delay-path trigger, `rst_out` stays 1 until `DELAY_TICKS` edges with `slow_tick` = 1 have been seen. It falls one edge after the last of these. A new trigger during the count restarts the count from zero.
- R3: Every edge with `pwr_ok` = 0 is a delay-path trigger with cause 2'b01. Reset is therefore held for the whole time the supply is not good, and for the full delay after it returns.
- R4: With control bit 5 = 1, a rising edge of `stop_wake` starts the delay path and sets cause 2'b11 (wake).
- R5: With control bit 5 = 0, the delay is skipped for wake. Once `stop_wake` has been sampled 1 at `HOLD_CYCLES` consecutive edges, `rst_out` is 1 for exactly one cycle after the last of them and the cause becomes 2'b11. Only one pulse is produced per assertion of `stop_wake`.
- R6: With control bit 5 = 0, a `stop_wake` pulse shorter than `HOLD_CYCLES` edges causes no reset and leaves the cause unchanged.
- R7: With control bit 4 = 1 and no reset active, the watchdog counts clock edges. An edge with `wdt_kick` = 1 restarts it. After `WDT_CYCLES` edges without a kick it triggers the delay path with cause 2'b10 (watchdog).
- R8: With control bit 4 = 0, the watchdog never causes a reset.
- R9: Bit 7 of the control register is cleared only by power-on reset. A value of 1 written by software survives supply-dip, watchdog and wake resets.
- R10: A supply-dip or watchdog trigger clears control bits 4..0 and keeps bits 7..5. A wake reset changes no register. The select registers are changed only by writes and by power-on.
- R11: When several sources trigger at the same edge, the cause recorded is power over watchdog over wake.
- R12: An edge with `reg_wr` = 1 writes `reg_wdata` to the register at `reg_addr` (0 control, 1 select A, 2 select B; address 3 is not used and reads 0). `reg_rdata` shows the register at `reg_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low (cold start) |
| pwr_ok | input | 1 | Supply good; low requests reset |
| slow_tick | input | 1 | One-cycle strobe of the slow delay timebase |
| stop_wake | input | 1 | Stop-mode recovery source, active high, synchronous |
| wdt_kick | input | 1 | Watchdog refresh |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rst_out | output | 1 | Internal reset, active high |
| rst_cause | output | 2 | Cause of the last reset: 01 power, 10 watchdog, 11 wake |

## Verification
The delay path is driven in turn by power-on, a supply dip, a watchdog expiry and a wake rise. Comparing release times separates a counter that restarts on a new trigger from one that only extends. Wake pulses of four edges and of eight edges, with the bypass on, tell the hold qualification apart from plain edge detection and show that only one pulse is produced. Watchdog runs with regular kicks, with no kicks and with the enable off, together with simultaneous supply-dip and wake triggers, check the cause priority and which register bits each kind of reset keeps.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_POWER = 2'd1,
      CAUSE_WDOG  = 2'd2,
      CAUSE_WAKE  = 2'd3
   } cause_e;

   localparam int CTL_WARM_BIT = 7;      // cleared only by power-on
   localparam int CTL_DLY_BIT  = 5;      // 1: wake uses the delay
   localparam int CTL_WDEN_BIT = 4;      // watchdog enable
   localparam int CTL_CLR_MSB  = 4;      // bits [CTL_CLR_MSB:0] cleared by dip/watchdog
   localparam logic [7:0] CTL_POR_VALUE = 8'h20;
   localparam int ADDR_W = 2;
endpackage

// File: rtl/rstseq_regs.sv
`timescale 1ns/1ps
module rstseq_regs
   import rstseq_pkg::*;
#(
   parameter int NUM_SEL = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              clr_low,
   output logic [7:0]        rdata,
   output logic              dly_en,
   output logic              wdt_en
);
   initial begin
      if (NUM_SEL < 1 || NUM_SEL > (1 << ADDR_W) - 1)
         $fatal(1, "rstseq_regs: NUM_SEL out of range");
   end

   logic [7:0] ctl_q, ctl_d;
   logic [NUM_SEL-1:0][7:0] sel_rd;

   always_comb begin
      ctl_d = ctl_q;
      if (wr && addr == '0) ctl_d = wdata;
      if (clr_low) ctl_d[CTL_CLR_MSB:0] = '0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) ctl_q <= CTL_POR_VALUE;
      else        ctl_q <= ctl_d;
   end

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      logic [7:0] sel_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                             sel_q <= '0;
         else if (wr && addr == ADDR_W'(g + 1))  sel_q <= wdata;
      end
      assign sel_rd[g] = sel_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) rdata = ctl_q;
      for (int i = 0; i < NUM_SEL; i++)
         if (addr == ADDR_W'(i + 1)) rdata = sel_rd[i];
   end

   assign dly_en = ctl_q[CTL_DLY_BIT];
   assign wdt_en = ctl_q[CTL_WDEN_BIT];

   // R10: a dip or watchdog trigger leaves the low control bits at zero
   a_r10_clear_low: assert property (@(posedge clk) disable iff (!por_n)
      clr_low |=> ctl_q[CTL_CLR_MSB:0] == '0);
   // R9: the warm flag never falls without power-on unless software writes it
   a_r9_warm_kept: assert property (@(posedge clk) disable iff (!por_n)
      (ctl_q[CTL_WARM_BIT] && !(wr && addr == '0)) |=> ctl_q[CTL_WARM_BIT]);
   // R12: a plain control write lands as written
   a_r12_write: assert property (@(posedge clk) disable iff (!por_n)
      (wr && addr == '0 && !clr_low) |=> ctl_q == $past(wdata));
endmodule

// File: rtl/rstseq_wdog.sv
`timescale 1ns/1ps
module rstseq_wdog #(
   parameter int WDT_CYCLES = 1024
) (
   input  logic clk,
   input  logic por_n,
   input  logic en,
   input  logic hold,
   input  logic kick,
   output logic fire
);
   initial begin
      if (WDT_CYCLES < 2) $fatal(1, "rstseq_wdog: WDT_CYCLES must be at least 2");
   end

   localparam int CW = $clog2(WDT_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign fire = en && !hold && !kick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                           cnt_q <= '0;
      else if (hold || !en || kick || fire) cnt_q <= '0;
      else                                  cnt_q <= cnt_q + 1'b1;
   end

   // R7: a refresh always buys at least one more cycle
   a_r7_kick_defers: assert property (@(posedge clk) disable iff (!por_n)
      kick |=> !fire);
   // R8: expiry never happens while disabled
   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
      !en |=> (!fire || $past(en) == 1'b0 && en));
endmodule

// File: rtl/rstseq_wake.sv
`timescale 1ns/1ps
module rstseq_wake #(
   parameter int HOLD_CYCLES = 5
) (
   input  logic clk,
   input  logic por_n,
   input  logic stop_wake,
   input  logic dly_en,
   output logic delay_trig,
   output logic bypass_trig
);
   initial begin
      if (HOLD_CYCLES < 1) $fatal(1, "rstseq_wake: HOLD_CYCLES must be at least 1");
   end

   logic stop_q;
   logic rise;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stop_q <= 1'b0;
      else        stop_q <= stop_wake;
   end

   assign rise       = stop_wake && !stop_q;
   assign delay_trig = rise && dly_en;

   if (HOLD_CYCLES == 1) begin : g_edge
      assign bypass_trig = rise && !dly_en;
   end else begin : g_count
      localparam int HW = $clog2(HOLD_CYCLES + 1);
      localparam logic [HW-1:0] FULL = HW'(HOLD_CYCLES);
      localparam logic [HW-1:0] LAST = HW'(HOLD_CYCLES - 1);
      logic [HW-1:0] hold_q;

      assign bypass_trig = stop_wake && !dly_en && (hold_q == LAST);

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                  hold_q <= '0;
         else if (!stop_wake || dly_en) hold_q <= '0;
         else if (hold_q != FULL)     hold_q <= hold_q + 1'b1;
      end

      // R6: qualification needs the source high on the previous edge too
      a_r6_held: assert property (@(posedge clk) disable iff (!por_n)
         bypass_trig |-> $past(stop_wake));
   end

   // R5: the bypass and delay wake paths exclude each other
   a_r5_exclusive: assert property (@(posedge clk) disable iff (!por_n)
      !(delay_trig && bypass_trig));
endmodule

// File: rtl/rstseq_delay.sv
`timescale 1ns/1ps
module rstseq_delay #(
   parameter int DELAY_TICKS = 64
) (
   input  logic clk,
   input  logic por_n,
   input  logic trig,
   input  logic tick,
   output logic busy
);
   initial begin
      if (DELAY_TICKS < 1) $fatal(1, "rstseq_delay: DELAY_TICKS must be at least 1");
   end

   localparam int CW = $clog2(DELAY_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (trig) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q && tick) begin
         if (cnt_q == LAST) busy_q <= 1'b0;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;

   // R2: a trigger always (re)asserts the hold
   a_r2_restart: assert property (@(posedge clk) disable iff (!por_n)
      trig |=> busy);
   // R2: without a tick the hold cannot end
   a_r2_no_early_end: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !tick) |=> busy);
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ns/1ps
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int DELAY_TICKS = 64,
   parameter int HOLD_CYCLES = 5,
   parameter int WDT_CYCLES  = 1024,
   parameter int NUM_SEL     = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       pwr_ok,
   input  logic       slow_tick,
   input  logic       stop_wake,
   input  logic       wdt_kick,
   input  logic       reg_wr,
   input  logic [1:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       rst_out,
   output logic [1:0] rst_cause
);
   logic   pwr_trig, wdt_fire, wake_dly, wake_byp;
   logic   dly_en, wdt_en, busy, pulse_q, rst_now;
   cause_e cause_q;

   assign pwr_trig = !pwr_ok;
   assign rst_now  = busy || pulse_q;

   rstseq_regs #(.NUM_SEL(NUM_SEL)) u_regs (
      .clk(clk), .por_n(por_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .clr_low(pwr_trig || wdt_fire), .rdata(reg_rdata), .dly_en(dly_en), .wdt_en(wdt_en)
   );

   rstseq_wdog #(.WDT_CYCLES(WDT_CYCLES)) u_wdog (
      .clk(clk), .por_n(por_n), .en(wdt_en), .hold(rst_now), .kick(wdt_kick), .fire(wdt_fire)
   );

   rstseq_wake #(.HOLD_CYCLES(HOLD_CYCLES)) u_wake (
      .clk(clk), .por_n(por_n), .stop_wake(stop_wake), .dly_en(dly_en),
      .delay_trig(wake_dly), .bypass_trig(wake_byp)
   );

   rstseq_delay #(.DELAY_TICKS(DELAY_TICKS)) u_delay (
      .clk(clk), .por_n(por_n), .trig(pwr_trig || wdt_fire || wake_dly),
      .tick(slow_tick), .busy(busy)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pulse_q <= 1'b0;
         cause_q <= CAUSE_POWER;
      end else begin
         pulse_q <= wake_byp;
         if (pwr_trig)                  cause_q <= CAUSE_POWER;
         else if (wdt_fire)             cause_q <= CAUSE_WDOG;
         else if (wake_dly || wake_byp) cause_q <= CAUSE_WAKE;
      end
   end

   assign rst_out   = rst_now;
   assign rst_cause = cause_q;

   // R3, R11: a supply dip wins and holds reset
   a_r3_dip_holds: assert property (@(posedge clk) disable iff (!por_n)
      !pwr_ok |=> rst_out && rst_cause == CAUSE_POWER);
   // R11: watchdog outranks wake
   a_r11_wdog_over_wake: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_fire && pwr_ok) |=> rst_out && rst_cause == CAUSE_WDOG);
   // R5: the bypass pulse lasts one cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
      pulse_q |=> !pulse_q);
   // R10: a wake reset alone leaves the registers alone
   a_r10_wake_keeps: assert property (@(posedge clk) disable iff (!por_n)
      ((wake_dly || wake_byp) && pwr_ok && !wdt_fire && !reg_wr)
         |=> (reg_addr != $past(reg_addr)) || $stable(reg_rdata));
endmodule

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;
   localparam int DT = 6;
   localparam int HC = 5;
   localparam int WC = 20;

   logic clk = 1'b0;
   logic por_n = 1'b0, pwr_ok = 1'b1, slow_tick = 1'b0, stop_wake = 1'b0, wdt_kick = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       rst_out;
   logic [1:0] rst_cause;

   int checks = 0, fails = 0, hi_cnt = 0, tdiv = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   rstseq_top #(.DELAY_TICKS(DT), .HOLD_CYCLES(HC), .WDT_CYCLES(WC), .NUM_SEL(2)) i_rstseq_top (
      .clk(clk), .por_n(por_n), .pwr_ok(pwr_ok), .slow_tick(slow_tick), .stop_wake(stop_wake),
      .wdt_kick(wdt_kick), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rst_out(rst_out), .rst_cause(rst_cause)
   );

   // behavioural reference
   int m_left, m_pulse, m_cause, m_wdt, m_hold, m_prev_stop;
   bit m_in_rst;
   int m_ctl, m_sel[2];

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_in_rst = 1; m_left = DT; m_pulse = 0; m_cause = 1; m_wdt = 0;
         m_hold = 0; m_prev_stop = 0; m_ctl = 'h20; m_sel[0] = 0; m_sel[1] = 0;
      end else begin
         bit now_rst, dip, dog, wk, byp;
         now_rst = m_in_rst || (m_pulse != 0);
         dip = !pwr_ok;
         dog = ((m_ctl & 'h10) != 0) && !now_rst && !wdt_kick && (m_wdt == WC - 1);
         wk  = stop_wake && (m_prev_stop == 0) && ((m_ctl & 'h20) != 0);
         byp = stop_wake && ((m_ctl & 'h20) == 0) && (m_hold == HC - 1);
         if (now_rst || (m_ctl & 'h10) == 0 || wdt_kick || dog) m_wdt = 0; else m_wdt++;
         if (!stop_wake || (m_ctl & 'h20) != 0) m_hold = 0; else if (m_hold < HC) m_hold++;
         m_pulse = byp;
         if (dip || dog || wk) begin m_in_rst = 1; m_left = DT; end
         else if (m_in_rst && slow_tick) begin m_left--; if (m_left == 0) m_in_rst = 0; end
         if (dip) m_cause = 1; else if (dog) m_cause = 2; else if (wk || byp) m_cause = 3;
         if (reg_wr) begin
            if (reg_addr == 0) m_ctl = reg_wdata;
            else if (reg_addr == 1) m_sel[0] = reg_wdata;
            else if (reg_addr == 2) m_sel[1] = reg_wdata;
         end
         if (dip || dog) m_ctl = m_ctl & 'he0;
         m_prev_stop = stop_wake;
      end
   end

   function automatic int exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return m_ctl;
         2'd1: return m_sel[0];
         2'd2: return m_sel[1];
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison, 1 ns after the active edge
   always @(posedge clk) begin
      #1;
      if (!done) begin
         int er;
         er = (m_in_rst || m_pulse != 0) ? 1 : 0;
         check(rst_out == er[0], cur_req, "rst_out", rst_out, er);
         check(rst_cause == m_cause[1:0], cur_req, "rst_cause", rst_cause, m_cause);
         check(reg_rdata == exp_rd(reg_addr), cur_req, "reg_rdata", reg_rdata, exp_rd(reg_addr));
         if (rst_out) hi_cnt++;
      end
   end

   always @(negedge clk) begin
      tdiv = (tdiv + 1) % 3;
      slow_tick = (tdiv == 0);
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic wait_release;
      for (int i = 0; i < 200 && rst_out; i++) @(negedge clk);
   endtask

   initial begin
      int n;
      cyc(1);
      // R1: power-on state
      cur_req = "R1";
      check(rst_out == 1, "R1", "rst_out in por", rst_out, 1);
      check(rst_cause == 2'b01, "R1", "cause in por", rst_cause, 1);
      check(reg_rdata == 8'h20, "R9", "ctl in por", reg_rdata, 'h20);
      cyc(3); por_n = 1;
      wait_release;
      check(rst_out == 0, "R1", "released after delay", rst_out, 0);

      // R12: register access
      cur_req = "R12";
      wr_reg(2'd1, 8'h5A); wr_reg(2'd2, 8'hC3);
      reg_addr = 2'd1; cyc(1);
      check(reg_rdata == 8'h5A, "R12", "select A", reg_rdata, 'h5A);
      reg_addr = 2'd3; cyc(1);
      check(reg_rdata == 8'h00, "R12", "unused address", reg_rdata, 0);

      // R3: supply dip
      cur_req = "R3";
      reg_addr = 2'd0; pwr_ok = 0; cyc(3);
      check(rst_out == 1 && rst_cause == 2'b01, "R3", "dip holds", {rst_out, rst_cause}, 'b101);
      pwr_ok = 1; wait_release;

      // R4, R10, R9: delayed wake keeps registers
      cur_req = "R4";
      wr_reg(2'd0, 8'hA0);
      stop_wake = 1; cyc(2); stop_wake = 0;
      check(rst_out == 1 && rst_cause == 2'b11, "R4", "wake delay", {rst_out, rst_cause}, 'b111);
      cur_req = "R2";
      cyc(8); pwr_ok = 0; cyc(1); pwr_ok = 1;
      n = 0;
      for (int i = 0; i < 100 && rst_out; i++) begin @(negedge clk); n++; end
      check(n >= 15 && n <= 20, "R2", "restart length", n, 17);
      check(reg_rdata == 8'hA0, "R10", "ctl after dip", reg_rdata, 'hA0);
      reg_addr = 2'd1; cyc(1);
      check(reg_rdata == 8'h5A, "R10", "select kept", reg_rdata, 'h5A);

      // R6, R5: bypass qualification
      cur_req = "R6";
      reg_addr = 2'd0; wr_reg(2'd0, 8'h80);
      hi_cnt = 0; stop_wake = 1; cyc(4); stop_wake = 0; cyc(4);
      check(hi_cnt == 0, "R6", "short pulse ignored", hi_cnt, 0);
      cur_req = "R5";
      hi_cnt = 0; stop_wake = 1; cyc(8); stop_wake = 0; cyc(3);
      check(hi_cnt == 1, "R5", "one reset cycle", hi_cnt, 1);
      check(rst_cause == 2'b11, "R5", "wake cause", rst_cause, 3);

      // R8: watchdog disabled
      cur_req = "R8";
      hi_cnt = 0; cyc(60);
      check(hi_cnt == 0, "R8", "no reset while off", hi_cnt, 0);

      // R7: watchdog kicked, then starved
      cur_req = "R7";
      wr_reg(2'd0, 8'h90); hi_cnt = 0;
      for (int k = 0; k < 10; k++) begin cyc(7); wdt_kick = 1; cyc(1); wdt_kick = 0; end
      check(hi_cnt == 0, "R7", "kicked no reset", hi_cnt, 0);
      cyc(WC + 2);
      check(rst_out == 1 && rst_cause == 2'b10, "R7", "expiry", {rst_out, rst_cause}, 'b110);
      wait_release;
      check(reg_rdata == 8'h80, "R9", "warm kept, enable cleared", reg_rdata, 'h80);

      // R11: simultaneous dip and wake
      cur_req = "R11";
      wr_reg(2'd0, 8'hA0);
      pwr_ok = 0; stop_wake = 1; cyc(1); pwr_ok = 1; cyc(1);
      check(rst_cause == 2'b01, "R11", "power wins", rst_cause, 1);
      stop_wake = 0; wait_release;

      // R9: cold start clears warm flag
      cur_req = "R9";
      por_n = 0; cyc(2);
      check(reg_rdata == 8'h20, "R9", "cold flag", reg_rdata, 'h20);
      por_n = 1; reg_addr = 2'd2; cyc(1);
      check(reg_rdata == 8'h00, "R1", "select cleared", reg_rdata, 0);
      wait_release;

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog R1 act=hung exp=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule